// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes a small 8-bit processor core from normal execution into exception handling. Two kinds of exception exist: reset and interrupts; there is no trap or error exception. While the active-low reset input is low, the sequencer holds the core stopped and the bus quiet. After reset is released it reads the reset handler address from vector 0 and hands it to the core together with a condition code value whose interrupt mask bit is set.

Up to 28 interrupt requests map to vector numbers 3 to 30. At an instruction boundary reported by the core, the sequencer picks the eligible request with the lowest vector number. It saves the return PC and the condition code byte on the stack, reads the 16-bit handler address from the vector table at byte address vector*2 and hands the core a new PC, a new stack pointer and a condition code value with the mask bit set. Acceptance is withheld at the end of any instruction that writes the condition code register, so at least one more instruction runs first. A request that the mask cannot hold off may chain straight into a second entry at the end of a sequence.

The memory bus is byte-wide with zero wait states. Read data is taken at the clock edge that ends a read cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: While `res_n` is low, `busy` is 1 and `bus_rd`, `bus_wr` and `load_pc` are 0. After release the block reads byte address 0x0000 and then 0x0001, then pulses `load_pc` with `new_pc` = {byte at 0x0000, byte at 0x0001}, `exc_vec` = 0 and `new_ccr` = 0x80.
- R2: A low `res_n` at any clock edge aborts a sequence in progress and quiets the bus from the next cycle, and it takes priority over any interrupt request that is asserted at the same time.
- R3: With the block idle, an eligible request present and `insn_end` = 1 with `insn_ccr_wr` = 0, the first stack write is on the bus in the very next cycle. While idle, the bus does no cycle.
- R4: The push sequence is four byte writes, in this order: PC[15:8] to SP-2, PC[7:0] to SP-1, CCR to SP-4, CCR to SP-3. SP, PC and CCR are the values of `sp_in`, `pc_in` and `ccr_in` at acceptance. `new_sp` is SP-4.
- R5: Request bit k has vector number 3+k. The handler word is read high byte first, from byte address 2*vector and then from 2*vector+1. `new_pc` is {first byte, second byte}, and `exc_vec` gives the vector number.
- R6: When several eligible requests are pending, the lowest vector number is taken.
- R7: CCR bit 7 is the interrupt mask. While it is 1, only the requests selected by parameter `NOMASK` are eligible (the default is bit 0, vector 3). All others are ignored and the block stays idle.
- R8: When `insn_end` is 1 together with `insn_ccr_wr` = 1, no request is accepted. A request still pending is accepted at the next `insn_end` that has `insn_ccr_wr` = 0.
- R9: With each `load_pc` pulse, `new_ccr` is the saved CCR with bit 7 forced to 1.
- R10: In the cycle of `load_pc`, a pending request that the mask cannot hold off starts a new entry at once. This entry pushes the handler address just fetched and the new CCR, and it uses the new SP.
- R11: `bus_rd` and `bus_wr` are never 1 together, and `load_pc` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Active-low reset, sampled at every edge |
| irq_req | input | NIRQ | Interrupt requests; bit k maps to vector 3+k |
| insn_end | input | 1 | Core reports an instruction boundary |
| insn_ccr_wr | input | 1 | The instruction that is ending wrote the CCR |
| pc_in | input | 16 | Return PC at the boundary |
| ccr_in | input | 8 | Current CCR; bit 7 is the mask |
| sp_in | input | 16 | Current stack pointer |
| bus_addr | output | 16 | Bus byte address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, taken at the edge that ends a read |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| busy | output | 1 | Core must hold; a sequence is in progress |
| load_pc | output | 1 | One-cycle pulse: core loads the new PC, SP and CCR |
| new_pc | output | 16 | Handler address |
| new_sp | output | 16 | Stack pointer after the pushes |
| new_ccr | output | 8 | CCR with the mask bit set |
| exc_vec | output | 5 | Vector number taken (0 for reset) |

## Verification
The assertions assume that the core raises `insn_end` only while `busy` is low, and that `pc_in`, `ccr_in` and `sp_in` are valid in that cycle. The bench drives the core-side inputs only when the block is idle, and it changes them half a cycle away from the active edge. It lowers any request that the mask cannot hold off once the scenario has consumed it, so an entry does not repeat without end. The bus model answers reads in the same cycle from a small table that is indexed by the low address byte. This matches the zero-wait-state bus that the requirements describe.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int NIRQ = 28,
  parameter int VEC_BASE = 3,
  parameter int AW = 16,
  parameter int IBIT = 7,
  parameter logic [NIRQ-1:0] NOMASK = 1,
  localparam int VW = $clog2(VEC_BASE + NIRQ)
) (
  input  logic            clk,
  input  logic            res_n,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            insn_end,
  input  logic            insn_ccr_wr,
  input  logic [AW-1:0]   pc_in,
  input  logic [7:0]      ccr_in,
  input  logic [AW-1:0]   sp_in,
  output logic [AW-1:0]   bus_addr,
  output logic [7:0]      bus_wdata,
  input  logic [7:0]      bus_rdata,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            busy,
  output logic            load_pc,
  output logic [AW-1:0]   new_pc,
  output logic [AW-1:0]   new_sp,
  output logic [7:0]      new_ccr,
  output logic [VW-1:0]   exc_vec
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_PCH, ST_PCL, ST_CCH, ST_CCL, ST_VH, ST_VL, ST_DONE
  } state_t;

  localparam logic [7:0] IMASK = 8'(1 << IBIT);

  state_t        state;
  logic [AW-1:0] pc_q, sp_q;
  logic [7:0]    ccr_q, vhi_q, vlo_q;
  logic [VW-1:0] vec_q;

  function automatic logic [VW-1:0] pick_vec(input logic [NIRQ-1:0] r);
    pick_vec = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (r[i]) pick_vec = VW'(VEC_BASE + i);
  endfunction

  logic [NIRQ-1:0] elig_idle, elig_chain;
  assign elig_idle  = irq_req & (ccr_in[IBIT] ? NOMASK : {NIRQ{1'b1}});
  assign elig_chain = irq_req & NOMASK;

  logic take_idle, take_chain;
  assign take_idle  = (state == ST_IDLE) && insn_end && !insn_ccr_wr && (|elig_idle);
  assign take_chain = (state == ST_DONE) && (|elig_chain);

  always_ff @(posedge clk) begin
    if (!res_n) begin
      state <= ST_RST;
      vec_q <= '0;
      ccr_q <= '0;
      sp_q  <= '0;
      pc_q  <= '0;
    end else begin
      case (state)
        ST_RST:  state <= ST_VH;
        ST_IDLE: if (take_idle) begin
          pc_q  <= pc_in;
          ccr_q <= ccr_in;
          sp_q  <= sp_in - AW'(4);
          vec_q <= pick_vec(elig_idle);
          state <= ST_PCH;
        end
        ST_PCH:  state <= ST_PCL;
        ST_PCL:  state <= ST_CCH;
        ST_CCH:  state <= ST_CCL;
        ST_CCL:  state <= ST_VH;
        ST_VH: begin
          vhi_q <= bus_rdata;
          state <= ST_VL;
        end
        ST_VL: begin
          vlo_q <= bus_rdata;
          state <= ST_DONE;
        end
        ST_DONE: if (take_chain) begin
          pc_q  <= {vhi_q, vlo_q};
          ccr_q <= ccr_q | IMASK;
          sp_q  <= sp_q - AW'(4);
          vec_q <= pick_vec(elig_chain);
          state <= ST_PCH;
        end else begin
          state <= ST_IDLE;
        end
        default: state <= ST_RST;
      endcase
    end
  end

  logic [AW-1:0] vec_addr;
  assign vec_addr = AW'({vec_q, 1'b0});

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    case (state)
      ST_PCH: begin bus_wr = 1'b1; bus_addr = sp_q + AW'(2); bus_wdata = pc_q[15:8]; end
      ST_PCL: begin bus_wr = 1'b1; bus_addr = sp_q + AW'(3); bus_wdata = pc_q[7:0];  end
      ST_CCH: begin bus_wr = 1'b1; bus_addr = sp_q;          bus_wdata = ccr_q;      end
      ST_CCL: begin bus_wr = 1'b1; bus_addr = sp_q + AW'(1); bus_wdata = ccr_q;      end
      ST_VH:  begin bus_rd = 1'b1; bus_addr = vec_addr;                              end
      ST_VL:  begin bus_rd = 1'b1; bus_addr = vec_addr | AW'(1);                     end
      default: ;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign load_pc = (state == ST_DONE);
  assign new_pc  = {vhi_q, vlo_q};
  assign new_sp  = sp_q;
  assign new_ccr = ccr_q | IMASK;
  assign exc_vec = vec_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int NIRQ = 28,
  parameter int VEC_BASE = 3,
  parameter int IBIT = 7,
  parameter logic [NIRQ-1:0] NOMASK = 1,
  parameter int VW = 5
) (
  input logic            clk,
  input logic            res_n,
  input logic [NIRQ-1:0] irq_req,
  input logic            insn_end,
  input logic            insn_ccr_wr,
  input logic [7:0]      ccr_in,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic            busy,
  input logic            load_pc,
  input logic [7:0]      new_ccr,
  input logic [VW-1:0]   exc_vec
);

  AST_RESET_QUIET: assert property (@(posedge clk) !res_n |=> (busy && !bus_rd && !bus_wr && !load_pc)); // R2
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!res_n) !(bus_rd && bus_wr)); // R11
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!res_n) load_pc |=> !load_pc); // R11
  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!res_n) !busy |-> (!bus_rd && !bus_wr)); // R3
  AST_CCRWR_DEFER: assert property (@(posedge clk) disable iff (!res_n) (!busy && insn_end && insn_ccr_wr) |=> !busy); // R8
  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!res_n) (!busy && ccr_in[IBIT] && ((irq_req & NOMASK) == '0)) |=> !busy); // R7
  AST_LOAD_SETS_MASK: assert property (@(posedge clk) disable iff (!res_n) load_pc |-> new_ccr[IBIT]); // R9
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!res_n) load_pc |-> (exc_vec == '0 || (int'(exc_vec) >= VEC_BASE && int'(exc_vec) < VEC_BASE + NIRQ))); // R5

endmodule

bind exc_entry_seq exc_entry_chk #(
  .NIRQ(NIRQ), .VEC_BASE(VEC_BASE), .IBIT(IBIT), .NOMASK(NOMASK), .VW(VW)
) u_chk (
  .clk(clk), .res_n(res_n), .irq_req(irq_req), .insn_end(insn_end),
  .insn_ccr_wr(insn_ccr_wr), .ccr_in(ccr_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .busy(busy), .load_pc(load_pc), .new_ccr(new_ccr), .exc_vec(exc_vec)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        res_n = 1'b0;
  logic [27:0] irq_req = '0;
  logic        insn_end = 1'b0, insn_ccr_wr = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  ccr_in = '0;
  logic [15:0] bus_addr, new_pc, new_sp;
  logic [7:0]  bus_wdata, bus_rdata, new_ccr;
  logic        bus_rd, bus_wr, busy, load_pc;
  logic [4:0]  exc_vec;

  exc_entry_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [256];
  assign bus_rdata = mem[bus_addr[7:0]];

  int checks = 0, failures = 0;
  int log_n = 0, lp_n = 0, overlap = 0, dbl = 0;
  logic [15:0] log_a [32];
  logic [7:0]  log_d [32];
  logic        log_w [32];
  logic [15:0] lp_pc [4], lp_sp [4];
  logic [7:0]  lp_ccr [4];
  logic [4:0]  lp_vec [4];
  logic        prev_lp = 1'b0;

  always @(negedge clk) begin
    if (bus_rd && bus_wr) overlap++;
    if (bus_rd || bus_wr) begin
      if (log_n < 32) begin
        log_a[log_n] = bus_addr;
        log_d[log_n] = bus_wr ? bus_wdata : bus_rdata;
        log_w[log_n] = bus_wr;
      end
      log_n++;
    end
    if (load_pc === 1'b1) begin
      if (lp_n < 4) begin
        lp_pc[lp_n] = new_pc; lp_sp[lp_n] = new_sp;
        lp_ccr[lp_n] = new_ccr; lp_vec[lp_n] = exc_vec;
      end
      lp_n++;
      if (prev_lp) dbl++;
    end
    prev_lp = (load_pc === 1'b1);
  end

  function automatic logic [15:0] hv(input int v);
    return {8'(8'h40 + v), 8'(v * 3)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bus(input string tag, input int i, input logic w, input logic [15:0] a, input logic [7:0] d);
    chk({tag, " kind"}, 32'(log_w[i]), 32'(w));
    chk({tag, " addr"}, 32'(log_a[i]), 32'(a));
    chk({tag, " data"}, 32'(log_d[i]), 32'(d));
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clr_logs();
    log_n = 0; lp_n = 0;
  endtask

  task automatic pulse_end(input logic ccrw);
    insn_ccr_wr = ccrw; insn_end = 1'b1;
    step(1);
    insn_end = 1'b0; insn_ccr_wr = 1'b0;
  endtask

  task automatic t_reset();
    res_n = 1'b0;
    step(3);
    chk("R1 busy in reset", 32'(busy), 1);
    chk("R1 no read in reset", 32'(bus_rd), 0);
    chk("R1 no write in reset", 32'(bus_wr), 0);
    clr_logs();
    res_n = 1'b1;
    step(1);
    chk("R1 read after release", 32'(bus_rd), 1);
    step(4);
    chk("R1 bus count", log_n, 2);
    chk_bus("R1 vec hi", 0, 1'b0, 16'h0000, mem[0]);
    chk_bus("R1 vec lo", 1, 1'b0, 16'h0001, mem[1]);
    chk("R1 load count", lp_n, 1);
    chk("R1 new pc", 32'(lp_pc[0]), 32'(hv(0)));
    chk("R1 vec", 32'(lp_vec[0]), 0);
    chk("R9 reset ccr", 32'(lp_ccr[0]), 32'h80);
    chk("R1 idle after", 32'(busy), 0);
  endtask

  task automatic t_basic();
    clr_logs();
    pc_in = 16'h1234; sp_in = 16'h00F0; ccr_in = 8'h00; irq_req = 28'h1 << 5;
    pulse_end(1'b0);
    chk("R3 first push next cycle", 32'(bus_wr), 1);
    chk("R3 first push addr", 32'(bus_addr), 32'h00EE);
    irq_req = '0;
    step(8);
    chk("R4 bus count", log_n, 6);
    chk_bus("R4 push pch", 0, 1'b1, 16'h00EE, 8'h12);
    chk_bus("R4 push pcl", 1, 1'b1, 16'h00EF, 8'h34);
    chk_bus("R4 push ccr a", 2, 1'b1, 16'h00EC, 8'h00);
    chk_bus("R4 push ccr b", 3, 1'b1, 16'h00ED, 8'h00);
    chk_bus("R5 vec hi", 4, 1'b0, 16'h0010, mem[16]);
    chk_bus("R5 vec lo", 5, 1'b0, 16'h0011, mem[17]);
    chk("R5 new pc", 32'(lp_pc[0]), 32'(hv(8)));
    chk("R5 vec num", 32'(lp_vec[0]), 8);
    chk("R4 new sp", 32'(lp_sp[0]), 32'h00EC);
    chk("R9 new ccr", 32'(lp_ccr[0]), 32'h80);
    chk("R3 idle after", 32'(busy), 0);
  endtask

  task automatic t_priority();
    clr_logs();
    pc_in = 16'hBEEF; sp_in = 16'h0080; ccr_in = 8'h2A;
    irq_req = (28'h1 << 9) | (28'h1 << 2) | (28'h1 << 20);
    pulse_end(1'b0);
    irq_req = '0;
    step(8);
    chk("R6 vec num", 32'(lp_vec[0]), 5);
    chk("R6 new pc", 32'(lp_pc[0]), 32'(hv(5)));
    chk_bus("R4 ccr pushed", 2, 1'b1, 16'h007C, 8'h2A);
    chk("R9 ccr keeps bits", 32'(lp_ccr[0]), 32'hAA);
  endtask

  task automatic t_mask();
    clr_logs();
    pc_in = 16'h2000; sp_in = 16'h00C0; ccr_in = 8'h80; irq_req = 28'h1 << 4;
    pulse_end(1'b0);
    chk("R7 masked stays idle", 32'(busy), 0);
    step(3);
    chk("R7 masked no bus", log_n, 0);
    chk("R7 masked no load", lp_n, 0);
    irq_req = 28'h1 | (28'h1 << 4);
    pulse_end(1'b0);
    irq_req = '0;
    chk("R7 nonmaskable accepted", 32'(busy), 1);
    step(8);
    chk("R7 nonmaskable vec", 32'(lp_vec[0]), 3);
    chk("R7 nonmaskable pc", 32'(lp_pc[0]), 32'(hv(3)));
  endtask

  task automatic t_defer();
    clr_logs();
    pc_in = 16'h3000; sp_in = 16'h00F0; ccr_in = 8'h00; irq_req = 28'h1 << 1;
    pulse_end(1'b1);
    chk("R8 ccr write defers", 32'(busy), 0);
    chk("R8 ccr write no bus", 32'(bus_wr), 0);
    step(2);
    chk("R8 still idle", log_n, 0);
    pc_in = 16'h3002;
    pulse_end(1'b0);
    irq_req = '0;
    chk("R8 accepted next insn", 32'(busy), 1);
    step(8);
    chk("R8 vec", 32'(lp_vec[0]), 4);
    chk_bus("R8 pushed later pc", 1, 1'b1, 16'h00EF, 8'h02);
  endtask

  task automatic t_chain();
    clr_logs();
    pc_in = 16'h4444; sp_in = 16'h00F0; ccr_in = 8'h00; irq_req = 28'h1 << 6;
    pulse_end(1'b0);
    irq_req = 28'h1;
    step(6);
    chk("R10 first load", 32'(load_pc), 1);
    step(1);
    irq_req = '0;
    chk("R10 chained push starts", 32'(bus_wr), 1);
    step(8);
    chk("R10 load count", lp_n, 2);
    chk("R11 load pulses apart", dbl, 0);
    chk("R10 first vec", 32'(lp_vec[0]), 9);
    chk("R10 second vec", 32'(lp_vec[1]), 3);
    chk("R10 second pc", 32'(lp_pc[1]), 32'(hv(3)));
    chk("R10 second sp", 32'(lp_sp[1]), 32'h00E8);
    chk_bus("R10 push handler hi", 6, 1'b1, 16'h00EA, hv(9)[15:8]);
    chk_bus("R10 push handler lo", 7, 1'b1, 16'h00EB, hv(9)[7:0]);
    chk_bus("R10 push new ccr", 8, 1'b1, 16'h00E8, 8'h80);
  endtask

  task automatic t_reset_abort();
    clr_logs();
    pc_in = 16'h5555; sp_in = 16'h00F0; ccr_in = 8'h00; irq_req = 28'h1 << 5;
    pulse_end(1'b0);
    step(2);
    res_n = 1'b0;
    step(1);
    chk("R2 abort busy", 32'(busy), 1);
    chk("R2 abort no write", 32'(bus_wr), 0);
    chk("R2 abort no read", 32'(bus_rd), 0);
    step(2);
    clr_logs();
    res_n = 1'b1;
    step(4);
    irq_req = '0;
    chk("R2 reset wins vec", 32'(lp_vec[0]), 0);
    chk("R2 reset wins pc", 32'(lp_pc[0]), 32'(hv(0)));
    chk_bus("R2 reset read", 0, 1'b0, 16'h0000, mem[0]);
  endtask

  initial begin
    for (int v = 0; v < 32; v++) begin
      mem[2*v] = 8'(8'h40 + v);
      mem[2*v+1] = 8'(v * 3);
    end
    for (int a = 64; a < 256; a++) mem[a] = 8'h00;
    step(1);
    t_reset();
    t_basic();
    t_priority();
    t_mask();
    t_defer();
    t_chain();
    t_reset_abort();
    chk("R11 rd and wr never together", overlap, 0);
    chk("R11 load never two cycles", dbl, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule